// File: doc/BRIEF.md
# Microcoded external bus pattern sequencer

This block drives a set of general-purpose control lines toward an external memory from a small RAM of pattern words. One pattern word is executed per bus clock cycle, and each bus cycle is four cycles of the block clock, so the quarter phases come from a clock running four times faster than the bus. Every word gives each line one level for the first half of the bus cycle and another for the second half. The word also carries a repeat count, a loop marker, a last-word marker and two bits for a dual-role line. That line is either a plain output or a wait input, as set by a mode bit.

A host loads pattern words and a mode register while the sequencer is idle. It then pulses `start` with a start index and a read/write flag. The sequencer walks consecutive indices, expands repeats, and runs the single loop body as many times as the mode register's loop-count field asks. It stops after the final repetition of a word that carries the last-word marker, and then pulses `done`. In wait mode the second-half bit of the dual-role pair enables a freeze on the synchronized wait input. The first-half bit picks where the data-sample strobe falls on reads.

Top module: `bus_pattern_seq`

## Requirements
- R1: After reset `busy`, `done`, `sample` and every `gpl_out` line are 0, and the dual-role line is an output (`dual_oe`=1).
- R2: Each execution of a word lasts four clocks (quarters 1 to 4). Line i shows word bit 6+2i during quarters 1–2 and bit 7+2i during quarters 3–4. The lines change only when quarter 1 or quarter 3 begins.
- R3: The repeat field, word bits [1:0], makes the word execute once for 00, twice for 01, three times for 10 and four times for 11.
- R4: The loop body runs N+1 times, where N is mode register bits [2:1] written through `mode_wdata`. The body is every word from the first word with loop bit (bit 2) set to the next such word, both inclusive. Repeats apply on every pass.
- R5: Execution starts at `start_idx` and proceeds through consecutive indices. After the final repetition of a word with bit 3 set, `busy` falls and `done` is high for exactly one clock.
- R6: With mode bit 0 clear, `dual_oe` is 1, `dual_out` shows word bit 4 in quarters 1–2 and bit 5 in quarters 3–4, `sample` stays 0, and `wait_in` has no effect.
- R7: With mode bit 0 set, `dual_oe` is 0. When the current word has bit 5 set and `wait_in`, delayed by two flip-flops, is 1, all outputs and the sequence position hold until the delayed input is 0.
- R8: In wait mode on a read (`rd_op`=1 at start), `sample` pulses once per execution. With word bit 4 = 1 it pulses in quarter 3 of that execution; with bit 4 = 0 it pulses in quarter 1 of the following bus cycle.
- R9: While `busy` is 1, pattern RAM writes, mode writes and further `start` pulses have no effect.
- R10: Only one loop is formed per run. Loop bits found after the loop end has completed are treated as ordinary words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-phase clock, four per bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Pattern RAM write strobe |
| host_addr | input | AW | Pattern RAM write index |
| host_wdata | input | 6+2*NL | Pattern word to write |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 3 | Bit 0 wait-input mode, bits [2:1] loop count |
| start | input | 1 | Start pulse, taken while idle |
| start_idx | input | AW | First word index of the run |
| rd_op | input | 1 | Run is a read (enables sample strobes) |
| wait_in | input | 1 | Asynchronous wait request |
| gpl_out | output | NL | General-purpose control lines |
| dual_out | output | 1 | Dual-role line output level |
| dual_oe | output | 1 | Dual-role line output enable |
| sample | output | 1 | Data-sample strobe |
| busy | output | 1 | Sequencer running |
| done | output | 1 | One-clock end-of-run pulse |

## Verification
Two functions can fall in the same clock: the deferred sample strobe of the final word and the end-of-run `done` pulse. A read run in wait mode ends on a word with sample select 0. The reference model then expects `sample` and `done` to be high together in the clock after `busy` falls. A second overlap comes from a wait freeze that lands on a word with sample select 1. The wait is raised while that word repeats, and the model expects exactly one strobe per execution, so a freeze must neither duplicate nor lose a strobe. The total strobe count and the run length in clocks are also checked against values derived from the requirements.

// File: rtl/bus_pattern_seq.sv
module bus_pattern_seq #(
  parameter int NL = 3,
  parameter int AW = 5,
  localparam int WW = 6 + 2 * NL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [WW-1:0] host_wdata,
  input  logic          mode_we,
  input  logic [2:0]    mode_wdata,
  input  logic          start,
  input  logic [AW-1:0] start_idx,
  input  logic          rd_op,
  input  logic          wait_in,
  output logic [NL-1:0] gpl_out,
  output logic          dual_out,
  output logic          dual_oe,
  output logic          sample,
  output logic          busy,
  output logic          done
);
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] ram [DEPTH];
  logic [WW-1:0] w;
  logic [AW-1:0] ptr, ls;
  logic [1:0]    q, rcnt, lleft, lc;
  logic          din, rd_l, in_loop, used, pend, w1, w2, frz, is_end, is_start;

  assign w        = ram[ptr];
  assign frz      = busy & din & w[5] & w2;
  assign is_end   = in_loop & (ptr != ls);
  assign is_start = ~in_loop & ~used;

  always_ff @(posedge clk)
    if (host_we && !busy) ram[host_addr] <= host_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1 <= 1'b0; w2 <= 1'b0; din <= 1'b0; lc <= '0;
      busy <= 1'b0; done <= 1'b0; pend <= 1'b0; rd_l <= 1'b0;
      q <= '0; rcnt <= '0; lleft <= '0; ptr <= '0; ls <= '0;
      in_loop <= 1'b0; used <= 1'b0;
    end else begin
      w1   <= wait_in;
      w2   <= w1;
      done <= 1'b0;
      pend <= 1'b0;
      if (mode_we && !busy) begin
        din <= mode_wdata[0];
        lc  <= mode_wdata[2:1];
      end
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; ptr <= start_idx; q <= '0; rcnt <= '0;
          in_loop <= 1'b0; used <= 1'b0; rd_l <= rd_op;
        end
      end else if (!frz) begin
        q <= q + 2'd1;
        if (q == 2'd3) begin
          pend <= din & rd_l & ~w[4];
          if (rcnt != w[1:0]) begin
            rcnt <= rcnt + 2'd1;
          end else begin
            rcnt <= '0;
            if (w[3]) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else if (w[2] && is_end && lleft != 2'd0) begin
              lleft <= lleft - 2'd1;
              ptr   <= ls;
            end else begin
              ptr <= ptr + 1'b1;
              if (w[2] && is_end) begin
                in_loop <= 1'b0;
                used    <= 1'b1;
              end else if (w[2] && is_start) begin
                in_loop <= 1'b1;
                ls      <= ptr;
                lleft   <= lc;
              end
            end
          end
        end
      end
    end
  end

  for (genvar i = 0; i < NL; i++) begin : g_line
    assign gpl_out[i] = busy & (q[1] ? w[7+2*i] : w[6+2*i]);
  end

  assign dual_oe  = ~din;
  assign dual_out = busy & ~din & (q[1] ? w[5] : w[4]);
  assign sample   = pend | (busy & ~frz & (q == 2'd2) & din & rd_l & w[4]);
endmodule

module bus_pattern_seq_chk #(
  parameter int NL = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          frz,
  input logic          sample,
  input logic          pend,
  input logic [1:0]    q,
  input logic [NL-1:0] gpl_out
);
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_quarter_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && q[0]) |-> $stable(gpl_out));

  assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frz) |=> ($stable(q) && $stable(gpl_out)));

  assert_sample_place_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !pend) |-> (q == 2'd2));
endmodule

bind bus_pattern_seq bus_pattern_seq_chk #(.NL(NL)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .frz(frz),
  .sample(sample), .pend(pend), .q(q), .gpl_out(gpl_out)
);

// File: tb/tb_bus_pattern_seq.sv
module tb_bus_pattern_seq;
  localparam int NL = 3, AW = 5, WW = 6 + 2 * NL, DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, host_we = 1'b0, mode_we = 1'b0, start = 1'b0, rd_op = 1'b0, wait_in = 1'b0;
  logic [AW-1:0] host_addr = '0, start_idx = '0;
  logic [WW-1:0] host_wdata = '0;
  logic [2:0] mode_wdata = '0;
  logic [NL-1:0] gpl_out;
  logic dual_out, dual_oe, sample, busy, done;

  bus_pattern_seq #(.NL(NL), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .start(start), .start_idx(start_idx), .rd_op(rd_op), .wait_in(wait_in),
    .gpl_out(gpl_out), .dual_out(dual_out), .dual_oe(dual_oe),
    .sample(sample), .busy(busy), .done(done)
  );

  int checks = 0, fails = 0, busy_cnt = 0, samp_cnt = 0;
  bit run_cmp = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model
  logic [WW-1:0] ram_m [DEPTH];
  logic [WW-1:0] eq [$];
  bit m_busy, m_done, m_pend, m_din, m_rd, ws1, ws2;
  int m_q;
  int m_lc;

  initial for (int i = 0; i < DEPTH; i++) ram_m[i] = '0;

  function automatic void push_w(logic [WW-1:0] wd);
    for (int r = 0; r <= int'(wd[1:0]); r++) eq.push_back(wd);
  endfunction

  function automatic void build(int s);
    int p, e, j;
    bit lp_used;
    p = s; lp_used = 0;
    eq.delete();
    for (int g = 0; g < 2 * DEPTH; g++) begin
      if (ram_m[p][2] && !lp_used) begin
        lp_used = 1;
        e = (p + 1) % DEPTH;
        for (int n = 0; n < DEPTH && !ram_m[e][2]; n++) e = (e + 1) % DEPTH;
        for (int k = 0; k <= m_lc; k++) begin
          j = p;
          for (int n = 0; n < DEPTH; n++) begin
            push_w(ram_m[j]);
            if (ram_m[j][3]) return;
            if (j == e) break;
            j = (j + 1) % DEPTH;
          end
        end
        p = (e + 1) % DEPTH;
      end else begin
        push_w(ram_m[p]);
        if (ram_m[p][3]) return;
        p = (p + 1) % DEPTH;
      end
    end
  endfunction

  always @(posedge clk) begin
    logic [WW-1:0] cw;
    logic [NL-1:0] e_g;
    bit fz, hq, e_smp, e_do;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_pend = 0; m_din = 0; m_rd = 0;
      ws1 = 0; ws2 = 0; m_q = 0; m_lc = 0;
    end else begin
      cw = m_busy ? eq[0] : '0;
      fz = m_busy && m_din && cw[5] && ws2;
      m_done = 0; m_pend = 0;
      if (host_we && !m_busy) ram_m[host_addr] = host_wdata;
      if (mode_we && !m_busy) begin m_din = mode_wdata[0]; m_lc = int'(mode_wdata[2:1]); end
      if (!m_busy) begin
        if (start) begin
          build(int'(start_idx));
          m_busy = 1; m_q = 0; m_rd = rd_op;
        end
      end else if (!fz) begin
        if (m_q == 3) begin
          m_pend = m_din && m_rd && !cw[4];
          void'(eq.pop_front());
          if (eq.size() == 0) begin m_busy = 0; m_done = 1; end
        end
        m_q = (m_q + 1) % 4;
      end
      ws2 = ws1; ws1 = wait_in;
    end
    #5;
    if (run_cmp) begin
      cw = m_busy ? eq[0] : '0;
      fz = m_busy && m_din && cw[5] && ws2;
      hq = (m_q >= 2);
      for (int i = 0; i < NL; i++) e_g[i] = m_busy && (hq ? cw[7+2*i] : cw[6+2*i]);
      e_smp = m_pend || (m_busy && !fz && m_q == 2 && m_din && m_rd && cw[4]);
      e_do = m_busy && !m_din && (hq ? cw[5] : cw[4]);
      chk(gpl_out == e_g, "R2", "gpl_out", int'(gpl_out), int'(e_g));
      chk(dual_oe == !m_din, "R6", "dual_oe", int'(dual_oe), int'(!m_din));
      chk(dual_out == e_do, "R6", "dual_out", int'(dual_out), int'(e_do));
      chk(sample == e_smp, "R8", "sample", int'(sample), int'(e_smp));
      chk(busy == m_busy, "R5", "busy", int'(busy), int'(m_busy));
      chk(done == m_done, "R5", "done", int'(done), int'(m_done));
      busy_cnt += int'(busy);
      samp_cnt += int'(sample);
    end
  end

  function automatic logic [WW-1:0] mk(logic [2*NL-1:0] g, bit d2, bit d1, bit last, bit lp, logic [1:0] rep);
    return {g, d2, d1, last, lp, rep};
  endfunction

  task automatic wr(int a, logic [WW-1:0] wd);
    @(negedge clk); host_we = 1; host_addr = AW'(a); host_wdata = wd;
    @(negedge clk); host_we = 0;
  endtask

  task automatic setmode(bit wm, int lcount);
    @(negedge clk); mode_we = 1; mode_wdata = {2'(lcount), wm};
    @(negedge clk); mode_we = 0;
  endtask

  task automatic kick(int idx, bit rd);
    @(negedge clk);
    busy_cnt = 0; samp_cnt = 0;
    start = 1; start_idx = AW'(idx); rd_op = rd;
    @(negedge clk); start = 0;
  endtask

  task automatic finish_run();
    for (int n = 0; n < 2000 && !done; n++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL R5 watchdog actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1", "busy/done", int'({busy, done}), 0);
    chk(gpl_out == 0 && sample == 0, "R1", "gpl/sample", int'({gpl_out, sample}), 0);
    chk(dual_oe == 1, "R1", "dual_oe", int'(dual_oe), 1);
    run_cmp = 1;

    // program A: output mode, all repeat encodings
    wr(0, mk(6'b101001, 1, 0, 0, 0, 2'b00));
    wr(1, mk(6'b010110, 0, 1, 0, 0, 2'b01));
    wr(2, mk(6'b111000, 1, 1, 0, 0, 2'b10));
    wr(3, mk(6'b000111, 0, 1, 1, 0, 2'b11));
    kick(0, 1);
    repeat (6) @(negedge clk);
    wait_in = 1;
    repeat (8) @(negedge clk);
    wait_in = 0;
    finish_run();
    chk(busy_cnt == 40, "R3", "run clocks", busy_cnt, 40);
    chk(samp_cnt == 0, "R6", "samples in output mode", samp_cnt, 0);

    // R9: writes, mode write and start during a run are ignored
    kick(0, 0);
    @(negedge clk); host_we = 1; host_addr = 2; host_wdata = mk(6'b0, 0, 0, 1, 0, 2'b00);
    @(negedge clk); host_we = 0; mode_we = 1; mode_wdata = 3'b111;
    @(negedge clk); mode_we = 0; start = 1; start_idx = 8;
    @(negedge clk); start = 0;
    finish_run();
    chk(busy_cnt == 40, "R9", "run clocks after ignored writes", busy_cnt, 40);
    chk(dual_oe == 1, "R9", "mode after ignored write", int'(dual_oe), 1);

    // loop program
    wr(8,  mk(6'b000001, 0, 0, 0, 0, 2'b00));
    wr(9,  mk(6'b000010, 1, 0, 0, 1, 2'b01));
    wr(10, mk(6'b000100, 0, 1, 0, 0, 2'b00));
    wr(11, mk(6'b001000, 1, 1, 0, 1, 2'b00));
    wr(12, mk(6'b010000, 0, 0, 0, 1, 2'b00));
    wr(13, mk(6'b100000, 1, 0, 0, 0, 2'b00));
    wr(14, mk(6'b110011, 0, 1, 0, 1, 2'b00));
    wr(15, mk(6'b001100, 1, 1, 1, 0, 2'b00));
    setmode(0, 2);
    kick(8, 0);
    finish_run();
    chk(busy_cnt == 68, "R4", "loop x3 clocks", busy_cnt, 68);
    chk(busy_cnt != 80, "R10", "later loop bits ignored", busy_cnt, 68);
    setmode(0, 0);
    kick(8, 0);
    finish_run();
    chk(busy_cnt == 36, "R4", "loop x1 clocks", busy_cnt, 36);

    // wait-input mode, read, freeze and sample select
    wr(16, mk(6'b010101, 0, 0, 0, 0, 2'b00));
    wr(17, mk(6'b101010, 1, 1, 0, 0, 2'b11));
    wr(18, mk(6'b110110, 0, 0, 1, 0, 2'b00));
    setmode(1, 0);
    chk(dual_oe == 0, "R7", "dual_oe in wait mode", int'(dual_oe), 0);
    kick(16, 1);
    repeat (3) @(negedge clk);
    wait_in = 1;
    repeat (10) @(negedge clk);
    wait_in = 0;
    finish_run();
    chk(busy_cnt == 34, "R7", "run clocks with freeze", busy_cnt, 34);
    chk(samp_cnt == 6, "R8", "sample strobes", samp_cnt, 6);

    // wait enabled but not asserted: no stall
    kick(16, 0);
    finish_run();
    chk(busy_cnt == 24, "R7", "run clocks without wait", busy_cnt, 24);
    chk(samp_cnt == 0, "R8", "no strobes on write", samp_cnt, 0);

    run_cmp = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule